// File: doc/BRIEF.md
# Sideband Mailbox Register Bridge

This block is a slave bridge. It turns a small window of host registers into single transactions on a downstream sideband message port. A host sets up a transaction by loading three registers over a plain 32-bit register bus:

- an upper-offset word,
- a payload word, for write transactions,
- a command word, whose write launches the transaction.

The bridge then presents one request to the fabric, carrying an opcode, a destination port ID, a 32-bit offset and the payload. It waits for the matching response. Read results land in the payload register, where the host collects them.

Only one transaction is in flight at a time. A fourth register exposes status:

- busy,
- a rejected-command error,
- a sticky overrun flag, set by command writes that arrive while busy.

A host read of the payload register during a transaction is held off until the response has arrived. The register window sits at a parameterised base address. The default base is 0x00; 0xD0 is the setting for a configuration-space placement.

Top module: `sbmb_bridge`

## Requirements
- R1: After reset the payload, upper-offset and status registers read zero, and `req_valid` is low.
- R2: The registers sit at BASE+0x0 (command), BASE+0x4 (payload), BASE+0x8 (upper offset) and BASE+0xC (status: bit0 busy, bit1 error, bit2 overrun). Bits 7:0 of the upper-offset register always read zero, whatever is written.
- R3: The command word carries the opcode in bits 31:24, the port ID in 23:16, the low offset byte in 15:8 and a byte-enable nibble in 7:4. An accepted command write raises `req_valid` in the next cycle, with:
  - `req_op` and `req_port` copied from the command word,
  - `req_addr` = {upper-offset[31:8], command[15:8]},
  - `req_wdata` = the payload register's value at the time of the command write.
- R4: The only opcodes accepted are 0x00/0x01, 0x04/0x05, 0x06/0x07, 0x10/0x11 and 0x12/0x13. `req_write` equals opcode bit 0: even codes read, odd codes write.
- R5: A command write with an unlisted opcode, or with a byte-enable nibble other than 0xF, sends no request and sets status bit1. The next accepted command clears that bit.
- R6: The upper-offset register returns to zero when the bridge consumes a command write, whether the command is accepted or rejected.
- R7: While `req_valid` is high and `req_ready` is low, `req_valid` and every request field hold steady.
- R8: When a response arrives for a read opcode, `rsp_rdata` is loaded into the payload register. A response to a write opcode leaves the payload register unchanged.
- R9: Status bit0 is high from the cycle after an accepted command until the cycle after the response is taken. A payload-register read during that time sees `hst_ready` low.
- R10: A command write while busy is ignored and sets status bit2. That bit stays set until the host writes status with bit2 = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_wr | input | 1 | Host write strobe |
| hst_rd | input | 1 | Host read strobe |
| hst_addr | input | ADDR_W | Host byte address |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data |
| hst_ready | output | 1 | Low while a payload read must wait |
| req_valid | output | 1 | Downstream request valid |
| req_ready | input | 1 | Downstream request accepted |
| req_op | output | 8 | Request opcode |
| req_port | output | 8 | Request destination port ID |
| req_addr | output | 32 | Request offset |
| req_wdata | output | 32 | Request write payload |
| req_write | output | 1 | Request is a write |
| rsp_valid | input | 1 | Downstream response valid |
| rsp_ready | output | 1 | Bridge can take a response |
| rsp_rdata | input | 32 | Response data |

## Verification
The tests exercise command launching in several ways:

- a read with a loaded upper offset, which separates correct offset assembly from use of the low byte alone;
- a write with no upper offset, which exposes an offset register that failed to clear after the previous command;
- a sweep over every listed opcode plus an unlisted neighbour, which separates the read/write direction and the accept/reject decision per code.

Further tests cover the hazards around busy:

- rejected commands, including a bad byte-enable nibble;
- a command write while busy;
- a payload read during a transaction.

These show whether an ignored command leaks a request, and whether read data is exposed before the response lands.

// File: rtl/sbmb_pkg.sv
package sbmb_pkg;
  localparam int DW = 32;

  // register offsets inside the window
  localparam int OFF_CMD  = 0;
  localparam int OFF_DATA = 4;
  localparam int OFF_XOFF = 8;
  localparam int OFF_STAT = 12;

  // accepted opcode classes: even code reads, code+1 writes
  localparam int N_CLASS = 5;
  localparam logic [7:0] CLASS_BASE [N_CLASS] = '{8'h00, 8'h04, 8'h06, 8'h10, 8'h12};

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_RSP} seq_st_e;

  typedef struct packed {
    logic [7:0]    op;
    logic [7:0]    port;
    logic [DW-1:0] addr;
    logic [DW-1:0] wdata;
    logic          write;
  } sb_req_t;
endpackage

// File: rtl/sbmb_cmdcheck.sv
module sbmb_cmdcheck
  import sbmb_pkg::*;
(
  input  logic [6:0] op_hi,
  input  logic [3:0] byte_en,
  output logic       cmd_ok
);
  logic [N_CLASS-1:0] hit;

  for (genvar i = 0; i < N_CLASS; i++) begin : g_class
    assign hit[i] = (op_hi == CLASS_BASE[i][7:1]);
  end

  assign cmd_ok = (|hit) && (byte_en == 4'hF);
endmodule

// File: rtl/sbmb_hostregs.sv
module sbmb_hostregs
  import sbmb_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_wr,
  input  logic              hst_rd,
  input  logic [ADDR_W-1:0] hst_addr,
  input  logic [DW-1:0]     hst_wdata,
  output logic [DW-1:0]     hst_rdata,
  output logic              hst_ready,
  input  logic              busy,
  input  logic              err,
  input  logic              ovr,
  input  logic              xoff_clr,
  input  logic              rsp_load,
  input  logic [DW-1:0]     rsp_data,
  output logic              cmd_wr,
  output logic              ovr_clr,
  output logic [DW-1:0]     data_q,
  output logic [DW-1:0]     xoff_q
);
  localparam logic [ADDR_W-1:0] A_CMD  = BASE_ADDR + ADDR_W'(OFF_CMD);
  localparam logic [ADDR_W-1:0] A_DATA = BASE_ADDR + ADDR_W'(OFF_DATA);
  localparam logic [ADDR_W-1:0] A_XOFF = BASE_ADDR + ADDR_W'(OFF_XOFF);
  localparam logic [ADDR_W-1:0] A_STAT = BASE_ADDR + ADDR_W'(OFF_STAT);

  logic [DW-1:0] cmd_q, cmd_d, data_d, xoff_d;
  logic          sel_cmd, sel_data, sel_xoff, sel_stat;

  assign sel_cmd  = (hst_addr == A_CMD);
  assign sel_data = (hst_addr == A_DATA);
  assign sel_xoff = (hst_addr == A_XOFF);
  assign sel_stat = (hst_addr == A_STAT);

  assign cmd_wr  = hst_wr && sel_cmd;
  assign ovr_clr = hst_wr && sel_stat && hst_wdata[2];

  always_comb begin
    cmd_d  = cmd_q;
    data_d = data_q;
    xoff_d = xoff_q;
    if (cmd_wr) cmd_d = hst_wdata;
    if (rsp_load) data_d = rsp_data;
    else if (hst_wr && sel_data) data_d = hst_wdata;
    if (xoff_clr) xoff_d = '0;
    else if (hst_wr && sel_xoff) xoff_d = {hst_wdata[DW-1:8], 8'h00};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      data_q <= '0;
      xoff_q <= '0;
    end else begin
      cmd_q  <= cmd_d;
      data_q <= data_d;
      xoff_q <= xoff_d;
    end
  end

  always_comb begin
    hst_rdata = '0;
    if (sel_cmd)  hst_rdata = cmd_q;
    if (sel_data) hst_rdata = data_q;
    if (sel_xoff) hst_rdata = xoff_q;
    if (sel_stat) hst_rdata = {{(DW-3){1'b0}}, ovr, err, busy};
  end

  assign hst_ready = !(hst_rd && sel_data && busy);

  AST_DATA_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_rd && sel_data && busy) |-> !hst_ready); // R9
  AST_XOFF_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    xoff_clr |=> (xoff_q == '0)); // R6
  AST_XOFF_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_wr && sel_xoff) |=> (xoff_q[7:0] == 8'h00)); // R2
endmodule

// File: rtl/sbmb_seq.sv
module sbmb_seq
  import sbmb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  logic          cmd_ok,
  input  logic [DW-1:0] cmd_word,
  input  logic [DW-1:0] data_q,
  input  logic [DW-1:0] xoff_q,
  input  logic          ovr_clr,
  input  logic          req_ready,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_rdata,
  output sb_req_t       req,
  output logic          req_valid,
  output logic          rsp_ready,
  output logic          busy,
  output logic          err,
  output logic          ovr,
  output logic          xoff_clr,
  output logic          rsp_load,
  output logic [DW-1:0] rsp_data
);
  seq_st_e st_q, st_d;
  sb_req_t req_q, req_d;
  logic    err_d, ovr_d, accept;

  assign busy      = (st_q != ST_IDLE);
  assign accept    = cmd_wr && !busy;
  assign xoff_clr  = accept;
  assign req_valid = (st_q == ST_REQ);
  assign rsp_ready = (st_q == ST_RSP);
  assign rsp_load  = rsp_ready && rsp_valid && !req_q.write;
  assign rsp_data  = rsp_rdata;
  assign req       = req_q;

  always_comb begin
    st_d  = st_q;
    req_d = req_q;
    err_d = err;
    ovr_d = ovr;
    unique case (st_q)
      ST_IDLE: if (accept) begin
        err_d = !cmd_ok;
        if (cmd_ok) begin
          st_d        = ST_REQ;
          req_d.op    = cmd_word[31:24];
          req_d.port  = cmd_word[23:16];
          req_d.addr  = {xoff_q[DW-1:8], cmd_word[15:8]};
          req_d.wdata = data_q;
          req_d.write = cmd_word[24];
        end
      end
      ST_REQ:  if (req_ready) st_d = ST_RSP;
      ST_RSP:  if (rsp_valid) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
    if (cmd_wr && busy) ovr_d = 1'b1;
    else if (ovr_clr)   ovr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      req_q <= '0;
      err   <= 1'b0;
      ovr   <= 1'b0;
    end else begin
      st_q  <= st_d;
      req_q <= req_d;
      err   <= err_d;
      ovr   <= ovr_d;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req))); // R7
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !rsp_ready); // R9
  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && busy) |=> ovr); // R10
  AST_BAD_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !busy && !cmd_ok) |=> (!req_valid && err)); // R5
  AST_DIR_FROM_OP: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req.write == req.op[0])); // R4
endmodule

// File: rtl/sbmb_bridge.sv
module sbmb_bridge
  import sbmb_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_wr,
  input  logic              hst_rd,
  input  logic [ADDR_W-1:0] hst_addr,
  input  logic [31:0]       hst_wdata,
  output logic [31:0]       hst_rdata,
  output logic              hst_ready,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [7:0]        req_op,
  output logic [7:0]        req_port,
  output logic [31:0]       req_addr,
  output logic [31:0]       req_wdata,
  output logic              req_write,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [31:0]       rsp_rdata
);
  logic          busy, err, ovr, xoff_clr, rsp_load, cmd_wr, ovr_clr, cmd_ok;
  logic [DW-1:0] data_q, xoff_q, rsp_data;
  sb_req_t       req;

  sbmb_hostregs #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_rd(hst_rd),
    .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
    .hst_ready(hst_ready), .busy(busy), .err(err), .ovr(ovr),
    .xoff_clr(xoff_clr), .rsp_load(rsp_load), .rsp_data(rsp_data),
    .cmd_wr(cmd_wr), .ovr_clr(ovr_clr), .data_q(data_q), .xoff_q(xoff_q)
  );

  sbmb_cmdcheck u_chk (
    .op_hi(hst_wdata[31:25]), .byte_en(hst_wdata[7:4]), .cmd_ok(cmd_ok)
  );

  sbmb_seq u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_ok(cmd_ok),
    .cmd_word(hst_wdata), .data_q(data_q), .xoff_q(xoff_q),
    .ovr_clr(ovr_clr), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .req(req), .req_valid(req_valid),
    .rsp_ready(rsp_ready), .busy(busy), .err(err), .ovr(ovr),
    .xoff_clr(xoff_clr), .rsp_load(rsp_load), .rsp_data(rsp_data)
  );

  assign req_op    = req.op;
  assign req_port  = req.port;
  assign req_addr  = req.addr;
  assign req_wdata = req.wdata;
  assign req_write = req.write;

  AST_READ_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready && !req_write) |=> (data_q == $past(rsp_rdata))); // R8
endmodule

// File: tb/sbmb_bridge_tb.sv
module sbmb_bridge_tb;
  logic        clk, rst_n;
  logic        hst_wr, hst_rd;
  logic [7:0]  hst_addr;
  logic [31:0] hst_wdata, hst_rdata;
  logic        hst_ready;
  logic        req_valid, req_ready, req_write, rsp_valid, rsp_ready;
  logic [7:0]  req_op, req_port;
  logic [31:0] req_addr, req_wdata, rsp_rdata;

  int checks = 0, failures = 0;
  bit done = 0;

  sbmb_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_rd(hst_rd),
    .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
    .hst_ready(hst_ready), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_port(req_port), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_write(req_write), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hwrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    hst_wr = 1; hst_addr = a; hst_wdata = d;
    @(negedge clk);
    hst_wr = 0;
  endtask

  task automatic hread(input logic [7:0] a, output logic [31:0] d, output logic rdy);
    hst_rd = 1; hst_addr = a;
    #1;
    d = hst_rdata; rdy = hst_ready;
    hst_rd = 0;
  endtask

  task automatic expect_reg(input logic [7:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] d; logic r;
    hread(a, d, r);
    chk(d == exp, tag, d, exp);
  endtask

  // waits for a request, checks it, holds ready low for hold cycles, then answers
  task automatic serve(input logic [7:0] op, input logic [7:0] port, input logic [31:0] addr,
                       input logic [31:0] wd, input int hold, input logic [31:0] rd);
    int n = 0;
    while (!req_valid && n < 20) begin @(negedge clk); n++; end
    chk(req_valid, "R3 request raised", {31'b0, req_valid}, 1);
    chk(req_op == op && req_port == port, "R3 op/port", {req_op, req_port}, {op, port});
    chk(req_addr == addr, "R3 offset", req_addr, addr);
    chk(req_write == op[0], "R4 direction", {31'b0, req_write}, {31'b0, op[0]});
    if (op[0]) chk(req_wdata == wd, "R3 payload", req_wdata, wd);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(req_valid && req_addr == addr && req_op == op, "R7 hold", req_addr, addr);
    end
    req_ready = 1;
    @(negedge clk);
    req_ready = 0;
    rsp_valid = 1; rsp_rdata = rd;
    @(negedge clk);
    rsp_valid = 0;
  endtask

  task automatic t_reset;
    chk(req_valid == 0, "R1 req_valid", {31'b0, req_valid}, 0);
    expect_reg(8'h04, 0, "R1 data");
    expect_reg(8'h08, 0, "R1 xoff");
    expect_reg(8'h0C, 0, "R1 status");
  endtask

  task automatic t_xoff_mask;
    hwrite(8'h08, 32'h12345678);
    expect_reg(8'h08, 32'h12345600, "R2 xoff low byte");
  endtask

  task automatic t_read_txn;
    logic [31:0] d; logic r;
    hwrite(8'h08, 32'hABCDEF00);
    hwrite(8'h00, 32'h10040EF0);
    expect_reg(8'h0C, 32'h1, "R9 busy");
    expect_reg(8'h08, 0, "R6 xoff cleared");
    serve(8'h10, 8'h04, 32'hABCDEF0E, 0, 2, 32'hCAFEF00D);
    hread(8'h04, d, r);
    chk(r && d == 32'hCAFEF00D, "R8 read result", d, 32'hCAFEF00D);
    expect_reg(8'h0C, 0, "R9 idle");
  endtask

  task automatic t_write_txn;
    hwrite(8'h04, 32'h11223344);
    hwrite(8'h00, 32'h110407F0);
    serve(8'h11, 8'h04, 32'h00000007, 32'h11223344, 0, 32'h0000DEAD);
    expect_reg(8'h04, 32'h11223344, "R8 write keeps data");
  endtask

  task automatic t_reject;
    hwrite(8'h08, 32'h55667700);
    hwrite(8'h00, 32'h020000F0);
    repeat (3) begin
      chk(!req_valid, "R5 no request bad op", {31'b0, req_valid}, 0);
      @(negedge clk);
    end
    expect_reg(8'h0C, 32'h2, "R5 error set");
    expect_reg(8'h08, 0, "R6 xoff cleared on reject");
    hwrite(8'h00, 32'h10000070);
    repeat (3) begin
      chk(!req_valid, "R5 no request bad be", {31'b0, req_valid}, 0);
      @(negedge clk);
    end
    expect_reg(8'h0C, 32'h2, "R5 error on be");
    hwrite(8'h00, 32'h04090AF0);
    serve(8'h04, 8'h09, 32'h0000000A, 0, 0, 32'h1);
    expect_reg(8'h0C, 0, "R5 error cleared");
  endtask

  task automatic t_opcodes;
    logic [7:0] ops [10] = '{8'h00, 8'h01, 8'h04, 8'h05, 8'h06, 8'h07, 8'h10, 8'h11, 8'h12, 8'h13};
    for (int i = 0; i < 10; i++) begin
      hwrite(8'h00, {ops[i], 8'h21, 8'h30, 8'hF0});
      serve(ops[i], 8'h21, 32'h00000030, 32'h00000001, 0, 32'h00000001);
    end
    hwrite(8'h00, 32'h142130F0);
    @(negedge clk);
    chk(!req_valid, "R4 unlisted 0x14", {31'b0, req_valid}, 0);
    expect_reg(8'h0C, 32'h2, "R4 unlisted error");
  endtask

  task automatic t_busy;
    logic [31:0] d; logic r;
    hwrite(8'h00, 32'h060100F0);
    @(negedge clk);
    chk(req_valid, "R3 req for busy test", {31'b0, req_valid}, 1);
    req_ready = 1;
    @(negedge clk);
    req_ready = 0;
    hst_wr = 1; hst_addr = 8'h00; hst_wdata = 32'h110000F0;
    @(negedge clk);
    hst_wr = 0;
    chk(!req_valid, "R10 ignored command", {31'b0, req_valid}, 0);
    expect_reg(8'h0C, 32'h5, "R10 overrun and busy");
    hread(8'h04, d, r);
    chk(r == 0, "R9 stall", {31'b0, r}, 0);
    rsp_valid = 1; rsp_rdata = 32'h0BADBEEF;
    @(negedge clk);
    rsp_valid = 0;
    hread(8'h04, d, r);
    chk(r && d == 32'h0BADBEEF, "R9 released", d, 32'h0BADBEEF);
    expect_reg(8'h0C, 32'h4, "R10 overrun sticky");
    hwrite(8'h0C, 32'h4);
    expect_reg(8'h0C, 0, "R10 overrun cleared");
  endtask

  initial begin
    hst_wr = 0; hst_rd = 0; hst_addr = 0; hst_wdata = 0;
    req_ready = 0; rsp_valid = 0; rsp_rdata = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_xoff_mask();
    t_read_txn();
    t_write_txn();
    t_reject();
    t_opcodes();
    t_busy();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule